// File: doc/BRIEF.md
# Four/Five Dual-Modulus Prescaler

This block divides a fast clock by either four or five. A single control input picks the modulus, and the output gives one divided-clock period per four or five input clocks. Inside, three flip-flops step through a short reflected-code sequence: 000, 001, 011, 010. When divide-by-five is chosen, one extra state, 100, is added before the sequence returns to 000.

The modulus control is read only in state 010, the decision point. A change at any other time is held off until the next decision point, so no period is ever cut short or stretched. A downstream programmable counter can therefore change the control input at any time. The 3-bit state is brought out so that it can be observed.

Top module: `dual_mod_prescaler`

## Requirements
- R1: A synchronous active-low reset sets the state to 000 and drives the divided clock low. The state stays at 000 while the reset is held.
- R2: From 000 the state always goes to 001, then 011, then 010, whatever the modulus control is doing.
- R3: In state 010 with modulus control high (1 = divide-by-4), the next state is 000. A cycle then lasts 4 clocks.
- R4: In state 010 with modulus control low (0 = divide-by-5), the next state is 100, and 100 is always followed by 000. A cycle then lasts 5 clocks.
- R5: The modulus control has no effect in any state other than 010. Toggling it there leaves the state sequence unchanged.
- R6: The divided clock is high exactly in states 011 and 010, so it is high for 2 input clocks per cycle. The spacing between its rising edges is 4 or 5 clocks, set by the control value sampled at the decision point in between.
- R7: Only the states 000, 001, 011, 010 and 100 are ever held. Any other value of the state register is replaced with 000 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| mod_ctl_i | input | 1 | Modulus select: 1 = divide by 4, 0 = divide by 5; sampled in state 010 only |
| div_clk_o | output | 1 | Divided clock |
| state_o | output | 3 | Current state of the three flip-flops |

## Verification
The assertions check on every clock the next state after each legal state, covering the fixed prefix, both branches at the decision point and the exit from 100. They also check that the state register never holds an illegal value and that the divided clock falls only when leaving 010. The bench's scenarios cover behaviour across many cycles. It sweeps all 32 five-decision patterns while the control toggles randomly outside the decision point, so it shows that control changes away from 010 never alter a period. It also measures every rising-edge spacing against the value sampled at the decision point. Recovery from a reset applied partway through a cycle is shown only by the bench.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  parameter int STATE_W = 3;
  typedef logic [STATE_W-1:0] pscl_state_t;

  localparam pscl_state_t S_IDLE = 3'b000;
  localparam pscl_state_t S_ONE  = 3'b001;
  localparam pscl_state_t S_TWO  = 3'b011;
  localparam pscl_state_t S_DEC  = 3'b010;
  localparam pscl_state_t S_EXT  = 3'b100;

  function automatic logic is_legal(pscl_state_t s);
    return (s == S_IDLE) || (s == S_ONE) || (s == S_TWO) ||
           (s == S_DEC)  || (s == S_EXT);
  endfunction
endpackage

// File: rtl/pscl_next_state.sv
module pscl_next_state
  import pscl_pkg::*;
#(
  parameter logic DIV4_LEVEL = 1'b1
) (
  input  pscl_state_t cur_i,
  input  logic        mod_ctl_i,
  output pscl_state_t nxt_o
);
  logic pick_short;
  assign pick_short = (mod_ctl_i == DIV4_LEVEL);

  always_comb begin
    unique case (cur_i)
      S_IDLE:  nxt_o = S_ONE;
      S_ONE:   nxt_o = S_TWO;
      S_TWO:   nxt_o = S_DEC;
      S_DEC:   nxt_o = pick_short ? S_IDLE : S_EXT;
      S_EXT:   nxt_o = S_IDLE;
      default: nxt_o = S_IDLE;
    endcase
  end
endmodule

// File: rtl/pscl_state_reg.sv
module pscl_state_reg
  import pscl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mod_ctl_i,
  input  pscl_state_t nxt_i,
  output pscl_state_t state_o
);
  pscl_state_t state_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= nxt_i;
  end

  assign state_o = state_q;

  // R2
  prefix_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |=> (state_q == S_ONE));
  // R2
  prefix_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ONE) |=> (state_q == S_TWO));
  // R2
  prefix_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TWO) |=> (state_q == S_DEC));
  // R3
  div4_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DEC && mod_ctl_i) |=> (state_q == S_IDLE));
  // R4
  div5_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DEC && !mod_ctl_i) |=> (state_q == S_EXT));
  // R4
  ext_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXT) |=> (state_q == S_IDLE));
  // R7
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_legal(state_q));
endmodule

// File: rtl/pscl_clk_decode.sv
module pscl_clk_decode
  import pscl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  pscl_state_t state_i,
  output logic        div_clk_o
);
  assign div_clk_o = state_i[1];

  // R6
  high_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_clk_o) |=> div_clk_o);
  // R6
  fall_at_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_clk_o) |-> ($past(state_i) == S_DEC));
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import pscl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mod_ctl_i,
  output logic       div_clk_o,
  output logic [2:0] state_o
);
  pscl_state_t cur_s;
  pscl_state_t nxt_s;

  pscl_next_state #(.DIV4_LEVEL(1'b1)) u_next (
    .cur_i    (cur_s),
    .mod_ctl_i(mod_ctl_i),
    .nxt_o    (nxt_s)
  );

  pscl_state_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mod_ctl_i(mod_ctl_i),
    .nxt_i    (nxt_s),
    .state_o  (cur_s)
  );

  pscl_clk_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (cur_s),
    .div_clk_o(div_clk_o)
  );

  assign state_o = cur_s;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (state_o == 3'b000 && !div_clk_o));
endmodule

// File: tb/dual_mod_prescaler_tb_top.sv
`timescale 1ns/1ps
module dual_mod_prescaler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc = 1'b1;
  logic div_clk;
  logic [2:0] st;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [2:0] exp_st;
  logic prev_div;
  logic last_mc;
  logic dec_mc;
  bit have_rise;
  int cyc;
  int last_rise;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  dual_mod_prescaler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mod_ctl_i(mc),
    .div_clk_o(div_clk), .state_o(st)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [2:0] model_next(logic [2:0] s, logic m);
    case (s)
      3'b000: return 3'b001;
      3'b001: return 3'b011;
      3'b011: return 3'b010;
      3'b010: return m ? 3'b000 : 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic rnd_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Drive m at a negedge, check outputs at the following negedge.
  task automatic step(input logic m);
    string tag;
    logic [2:0] prior;
    prior = exp_st;
    if (prior == 3'b010) begin
      tag = m ? "R3" : "R4";
      dec_mc = m;
    end else if (prior == 3'b100) tag = "R4";
    else if (m != last_mc) tag = "R5";
    else tag = "R2";
    mc = m;
    last_mc = m;
    exp_st = model_next(prior, m);
    @(negedge clk);
    cyc++;
    chk(st == exp_st, tag, st, exp_st);
    chk(st == 3'b000 || st == 3'b001 || st == 3'b011 || st == 3'b010 || st == 3'b100,
        "R7", st, exp_st);
    chk(div_clk == (exp_st == 3'b011 || exp_st == 3'b010), "R6", div_clk,
        (exp_st == 3'b011 || exp_st == 3'b010));
    if (div_clk && !prev_div) begin
      if (have_rise)
        chk((cyc - last_rise) == (dec_mc ? 4 : 5), "R6 period", cyc - last_rise,
            dec_mc ? 4 : 5);
      have_rise = 1;
      last_rise = cyc;
    end
    prev_div = div_clk;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cyc += 2;
    chk(st == 3'b000, "R1 state", st, 0);
    chk(div_clk == 1'b0, "R1 div", div_clk, 0);
    rst_n = 1'b1;
    exp_st = 3'b000;
    prev_div = 1'b0;
    have_rise = 0;
  endtask

  initial begin
    cyc = 0; last_mc = 1'b1; dec_mc = 1'b1; have_rise = 0; prev_div = 1'b0;
    exp_st = 3'b000; last_rise = 0;
    @(negedge clk);
    do_reset();
    // R3: steady divide-by-4
    for (int i = 0; i < 40; i++) step(1'b1);
    // R4: steady divide-by-5
    for (int i = 0; i < 40; i++) step(1'b0);
    // R5: toggle every clock
    for (int i = 0; i < 60; i++) step(i[0]);
    // R5: random control at random times
    for (int i = 0; i < 400; i++) step(rnd_bit());
    // R1: reset in the middle of a cycle
    while (exp_st != 3'b011) step(rnd_bit());
    do_reset();
    // Sweep all 5-decision patterns, random control away from the decision point
    for (int p = 0; p < 32; p++) begin
      for (int d = 0; d < 5; d++) begin
        while (exp_st != 3'b010) step(rnd_bit());
        step(p[d]);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule